// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 32-bit logical address into a physical address for a memory system that is split into 4096-byte pages. A small fully associative translation cache is searched first. A hit gives the frame number at once. A miss sends one read to a single-level page table in memory. The returned entry is checked for presence first and then for write permission. Present entries are written into the cache, with the slot to replace chosen in round-robin order. Each request ends with exactly one of three outcomes: a translated address, a page fault, or a protection fault.

The block accepts one request at a time. The request and response ports are valid/ready streams. The request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the response has been consumed, and it is also low while `flush` is high. Once `resp_valid` rises, the response holds its value until `resp_ready` is seen high at a clock edge. The table read port follows the same rule: `mem_req_valid` and `mem_req_addr` are held until `mem_req_ready` is high. The entry returns on any later cycle with `mem_resp_valid` high. The table base input is sampled when a request is accepted.

Top module: `page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0. The cache starts empty.
- R2: A successful translation (`resp_status` = 0) returns `resp_paddr` = {frame number, logical address bits 11:0}. For example, logical 0x00007B00 with page 7 in frame 42 gives 0x0002AB00.
- R3: A request whose page is in the cache makes no table read, and its response is valid in the cycle right after acceptance.
- R4: A request that misses the cache raises `mem_req_valid` in the cycle after acceptance, with address = table base + 4 × page number (modulo 2^32). It holds the request until `mem_req_ready` is high, and it responds only after `mem_resp_valid`.
- R5: A table entry uses bit 0 as present, bit 1 as writable, and bits 31:12 as the frame number. An entry with bit 0 clear gives `resp_status` = 1 (page fault) and `resp_paddr` = 0, whatever the access type. Such an entry is not cached, so the same page misses again.
- R6: On a present page, a write (`req_write` = 1) without the writable bit gives `resp_status` = 2 (protection fault) with `resp_paddr` = 0. Reads are always allowed. This applies on both the cache and the table path.
- R7: Every present entry read from the table is cached, including one whose access was refused. Later requests to that page hit.
- R8: The cache has 4 slots, filled and replaced in round-robin order. After misses on five distinct present pages, the first page misses again and the other four hit.
- R9: While `flush` is high, `req_ready` is 0, and all cache slots are invalidated in that cycle. Afterwards every page misses.
- R10: While `resp_valid` is high and `resp_ready` is low, `resp_valid`, `resp_paddr` and `resp_status` stay unchanged and `req_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cache slots |
| ptbr | input | 32 | Page table base address, sampled on request accept |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_addr | input | 32 | Logical address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| resp_valid | output | 1 | Response stream valid |
| resp_ready | input | 1 | Response stream ready |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_status | output | 2 | 0 = ok, 1 = page fault, 2 = protection fault |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Table read request accepted |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_resp_valid | input | 1 | Table entry returned this cycle |
| mem_resp_data | input | 32 | Table entry |

## Verification
The assertions check the stream rules on every cycle. Held responses and held table reads must stay stable, no request may be accepted while a response is pending or a flush is high, a fault must return a zero address, the status must never take the unused code, and the offset must pass through to any successful translation. Other behaviours are visible only across a sequence of requests, so only the bench scenarios can show them. These are hit and miss timing, the table entry address, whether an entry was cached, round-robin replacement, and the effect of a flush. The bench runs a reference cache model next to seeded random traffic with random back-pressure, plus directed cases for the worked example, faults and eviction order.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int ADDR_W  = 32;
  localparam int OFF_W   = 12;
  localparam int VPN_W   = ADDR_W - OFF_W;
  localparam int PTE_V   = 0;
  localparam int PTE_W   = 1;

  typedef enum logic [1:0] {
    XS_OK   = 2'd0,
    XS_PAGE = 2'd1,
    XS_PROT = 2'd2
  } xlate_status_e;
endpackage

// File: rtl/pxl_tlb.sv
module pxl_tlb
  import pxl_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [VPN_W-1:0] lk_frame,
  output logic             lk_wr,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_frame,
  input  logic             fill_wr
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic             ent_v  [ENTRIES];
  logic [VPN_W-1:0] ent_tag[ENTRIES];
  logic [VPN_W-1:0] ent_frm[ENTRIES];
  logic             ent_wr [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0] victim;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = ent_v[i] && (ent_tag[i] == lk_vpn);
  end

  always_comb begin
    lk_frame = '0;
    lk_wr    = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_frame = lk_frame | ent_frm[i];
        lk_wr    = lk_wr | ent_wr[i];
      end
    end
  end
  assign lk_hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_v[i]   <= 1'b0;
        ent_tag[i] <= '0;
        ent_frm[i] <= '0;
        ent_wr[i]  <= 1'b0;
      end
    end else if (flush) begin
      for (int i = 0; i < ENTRIES; i++) ent_v[i] <= 1'b0;
    end else if (fill_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (victim == IDX_W'(i)) begin
          ent_v[i]   <= 1'b1;
          ent_tag[i] <= fill_vpn;
          ent_frm[i] <= fill_frame;
          ent_wr[i]  <= fill_wr;
        end
      end
      victim <= (victim == IDX_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
    end
  end
endmodule

// File: rtl/pxl_rights.sv
module pxl_rights
  import pxl_pkg::*;
(
  input  logic          present,
  input  logic          writable,
  input  logic          is_write,
  output xlate_status_e status
);
  always_comb begin
    if (!present)                  status = XS_PAGE;
    else if (is_write && !writable) status = XS_PROT;
    else                           status = XS_OK;
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import pxl_pkg::*;
#(
  parameter int TLB_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic [1:0]        resp_status,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [ADDR_W-1:0] mem_resp_data
);
  typedef enum logic [1:0] {S_IDLE, S_MREQ, S_MWAIT, S_RESP} state_e;

  state_e            st;
  logic [VPN_W-1:0]  vpn_q;
  logic [OFF_W-1:0]  off_q;
  logic              wr_q;
  logic [ADDR_W-1:0] maddr_q;
  logic [ADDR_W-1:0] paddr_q;
  xlate_status_e     stat_q;

  logic [VPN_W-1:0]  in_vpn;
  logic [OFF_W-1:0]  in_off;
  logic              accept;
  logic              tlb_hit, tlb_wr;
  logic [VPN_W-1:0]  tlb_frame;
  logic              walk_sel, fill_en;
  logic [VPN_W-1:0]  pte_frame;
  logic              chk_present, chk_wr, chk_is_wr;
  xlate_status_e     chk_status;
  logic              unused_pte;

  assign in_vpn    = req_addr[ADDR_W-1:OFF_W];
  assign in_off    = req_addr[OFF_W-1:0];
  assign req_ready = (st == S_IDLE) && !flush;
  assign accept    = req_valid && req_ready;
  assign pte_frame = mem_resp_data[ADDR_W-1:OFF_W];
  assign unused_pte = ^mem_resp_data[OFF_W-1:PTE_W+1];

  assign walk_sel  = (st == S_MWAIT);
  assign fill_en   = walk_sel && mem_resp_valid && mem_resp_data[PTE_V];

  pxl_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_vpn(in_vpn), .lk_hit(tlb_hit), .lk_frame(tlb_frame), .lk_wr(tlb_wr),
    .fill_en(fill_en), .fill_vpn(vpn_q), .fill_frame(pte_frame),
    .fill_wr(mem_resp_data[PTE_W])
  );

  always_comb begin
    if (walk_sel) begin
      chk_present = mem_resp_data[PTE_V];
      chk_wr      = mem_resp_data[PTE_W];
      chk_is_wr   = wr_q;
    end else begin
      chk_present = 1'b1;
      chk_wr      = tlb_wr;
      chk_is_wr   = req_write;
    end
  end

  pxl_rights u_rights (
    .present(chk_present), .writable(chk_wr),
    .is_write(chk_is_wr), .status(chk_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vpn_q   <= '0;
      off_q   <= '0;
      wr_q    <= 1'b0;
      maddr_q <= '0;
      paddr_q <= '0;
      stat_q  <= XS_OK;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          vpn_q <= in_vpn;
          off_q <= in_off;
          wr_q  <= req_write;
          if (tlb_hit) begin
            stat_q  <= chk_status;
            paddr_q <= (chk_status == XS_OK) ? {tlb_frame, in_off} : '0;
            st      <= S_RESP;
          end else begin
            maddr_q <= ptbr + {{(OFF_W-2){1'b0}}, in_vpn, 2'b00};
            st      <= S_MREQ;
          end
        end
        S_MREQ: if (mem_req_ready) st <= S_MWAIT;
        S_MWAIT: if (mem_resp_valid) begin
          stat_q  <= chk_status;
          paddr_q <= (chk_status == XS_OK) ? {pte_frame, off_q} : '0;
          st      <= S_RESP;
        end
        S_RESP: if (resp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == S_MREQ);
  assign mem_req_addr  = maddr_q;
  assign resp_valid    = (st == S_RESP);
  assign resp_paddr    = paddr_q;
  assign resp_status   = stat_q;
endmodule

// File: rtl/pxl_checker.sv
module pxl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_addr,
  input logic        resp_valid,
  input logic        resp_ready,
  input logic [31:0] resp_paddr,
  input logic [1:0]  resp_status,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr
);
  logic [11:0] cap_off;
  always_ff @(posedge clk) begin
    if (!rst_n) cap_off <= '0;
    else if (req_valid && req_ready) cap_off <= req_addr[11:0];
  end

  a_r10_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr) && $stable(resp_status));
  a_r10_single: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !req_ready);
  a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r9_flush_block: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !req_ready);
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_status != 2'd0 |-> resp_paddr == 32'd0);
  a_r6_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_status != 2'd3);
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_status == 2'd0 |-> resp_paddr[11:0] == cap_off);
endmodule

bind page_xlate pxl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .resp_valid(resp_valid), .resp_ready(resp_ready),
  .resp_paddr(resp_paddr), .resp_status(resp_status),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr)
);

// File: tb/page_xlate_test.sv
module page_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] ptbr = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [31:0] resp_paddr;
  logic [1:0]  resp_status;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_data = '0;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // reference cache model
  bit          m_v  [4];
  logic [19:0] m_tag[4];
  logic [19:0] m_frm[4];
  bit          m_wr [4];
  int          m_rr = 0;

  always #2 clk = ~clk;

  page_xlate uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ptbr(ptbr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_paddr(resp_paddr), .resp_status(resp_status),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_resp_valid(mem_resp_valid),
    .mem_resp_data(mem_resp_data)
  );

  function automatic logic [31:0] pte_fn(input logic [19:0] vpn);
    logic [19:0] frm;
    if (vpn == 20'd7) return 32'h0002_A003;
    frm = (vpn * 20'd3 + 20'd1) ^ 20'h00A50;
    return {frm, 10'b0, 1'(vpn % 4 != 2), 1'(vpn % 6 != 5)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] a, input bit w,
                       output logic [1:0] st, output logic [31:0] pa, output bit hit);
    logic [19:0] vpn = a[31:12];
    logic [31:0] pte;
    hit = 0;
    for (int i = 0; i < 4; i++) begin
      if (m_v[i] && m_tag[i] == vpn) begin
        hit = 1;
        st = (w && !m_wr[i]) ? 2'd2 : 2'd0;
        pa = (st == 2'd0) ? {m_frm[i], a[11:0]} : 32'd0;
      end
    end
    if (!hit) begin
      pte = pte_fn(vpn);
      if (!pte[0]) begin
        st = 2'd1; pa = 32'd0;
      end else begin
        m_v[m_rr] = 1; m_tag[m_rr] = vpn; m_frm[m_rr] = pte[31:12]; m_wr[m_rr] = pte[1];
        m_rr = (m_rr + 1) % 4;
        st = (w && !pte[1]) ? 2'd2 : 2'd0;
        pa = (st == 2'd0) ? {pte[31:12], a[11:0]} : 32'd0;
      end
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(!req_ready, "R9 ready low during flush", 32'(req_ready), 32'd0);
    for (int i = 0; i < 4; i++) m_v[i] = 0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] a, input bit w, input logic [31:0] base, input string tg);
    logic [1:0] est;
    logic [31:0] epa, eaddr, hpa;
    logic [1:0] hst;
    bit ehit, seen;
    int lat, nreq, phase, cnt, k;
    model(a, w, est, epa, ehit);
    eaddr = base + {10'b0, a[31:12], 2'b00};
    @(negedge clk);
    ptbr = base; req_valid = 1'b1; req_addr = a; req_write = w;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = $urandom; req_write = $urandom % 2; ptbr = $urandom;
    lat = 1; nreq = 0; phase = 0; cnt = 0; seen = 0;
    if (ehit)
      chk(resp_valid && !mem_req_valid, {tg, " R3 hit answers next cycle"}, {resp_valid, mem_req_valid}, 32'd2);
    else
      chk(mem_req_valid && !resp_valid, {tg, " R4 miss reads table next cycle"}, {resp_valid, mem_req_valid}, 32'd1);
    while (!resp_valid && lat < 60) begin
      if (phase == 0 && mem_req_valid) begin
        if (!seen) begin
          seen = 1; nreq++;
          chk(mem_req_addr == eaddr, "R4 entry address", mem_req_addr, eaddr);
        end
        mem_req_ready = ($urandom % 3) != 0;
      end else if (phase == 0 && seen) begin
        mem_req_ready = 1'b0; phase = 1; cnt = $urandom % 3;
      end
      if (phase == 1) begin
        if (cnt == 0) begin
          mem_resp_valid = 1'b1; mem_resp_data = pte_fn(a[31:12]); phase = 2;
        end else cnt--;
      end else if (phase == 2) begin
        mem_resp_valid = 1'b0; mem_resp_data = $urandom; phase = 3;
      end
      @(negedge clk);
      lat++;
    end
    mem_resp_valid = 1'b0; mem_req_ready = 1'b0;
    chk(resp_valid, "R4 response arrives", 32'(resp_valid), 32'd1);
    chk(nreq == (ehit ? 0 : 1), {tg, " R3/R4 table read count"}, nreq, ehit ? 0 : 1);
    if (ehit) chk(lat == 1, "R3 hit latency", lat, 1);
    if (est == 2'd1) chk(resp_status == est, "R5 page fault status", resp_status, est);
    else if (est == 2'd2) chk(resp_status == est, "R6 protection status", resp_status, est);
    else chk(resp_status == est, "R2 ok status", resp_status, est);
    chk(resp_paddr == epa, (est == 2'd0) ? "R2 physical address" : "R5/R6 zero address on fault", resp_paddr, epa);
    hpa = resp_paddr; hst = resp_status;
    k = $urandom % 3;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      chk(resp_valid && resp_paddr == hpa && resp_status == hst && !req_ready,
          "R10 response held", resp_paddr, hpa);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(!resp_valid && req_ready, "R10 response consumed", {resp_valid, req_ready}, 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R1 reset state",
        {req_ready, resp_valid, mem_req_valid}, 32'h4);

    // worked example: page 7 in frame 42
    xlate(32'h0000_7B00, 1'b0, 32'h0, "R2 example miss");
    xlate(32'h0000_7B00, 1'b1, 32'h0, "R7 example hit");
    // absent page stays uncached
    xlate(32'h0000_5010, 1'b0, 32'h0001_0000, "R5 absent");
    xlate(32'h0000_5020, 1'b1, 32'h0001_0000, "R5 absent again");
    // read-only page: write refused but entry cached
    xlate(32'h0000_2004, 1'b1, 32'h0001_0000, "R6 walk");
    xlate(32'h0000_2008, 1'b1, 32'h0001_0000, "R7 cached refused");
    xlate(32'h0000_2FFF, 1'b0, 32'h0001_0000, "R6 read ok");
    // flush then miss
    do_flush();
    xlate(32'h0000_7000, 1'b0, 32'h0002_0000, "R9 after flush");
    // round-robin eviction
    do_flush();
    xlate(32'h0000_0100, 1'b0, 32'h0003_0000, "R8 fill0");
    xlate(32'h0000_1100, 1'b0, 32'h0003_0000, "R8 fill1");
    xlate(32'h0000_3100, 1'b0, 32'h0003_0000, "R8 fill2");
    xlate(32'h0000_4100, 1'b0, 32'h0003_0000, "R8 fill3");
    xlate(32'h0000_8100, 1'b0, 32'h0003_0000, "R8 fill4");
    xlate(32'h0000_1200, 1'b0, 32'h0003_0000, "R8 kept1");
    xlate(32'h0000_3200, 1'b0, 32'h0003_0000, "R8 kept2");
    xlate(32'h0000_4200, 1'b0, 32'h0003_0000, "R8 kept3");
    xlate(32'h0000_8200, 1'b0, 32'h0003_0000, "R8 kept4");
    xlate(32'h0000_0200, 1'b0, 32'h0003_0000, "R8 evicted");
    // table base wraps around
    do_flush();
    xlate(32'hFFFF_F040, 1'b0, 32'hFFF0_0000, "R4 wrap");

    // seeded random traffic
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      a = {($urandom % 8 == 0) ? 20'($urandom) : 20'($urandom % 10), 12'($urandom)};
      if ($urandom % 16 == 0) do_flush();
      xlate(a, $urandom % 2, 32'h0010_0000, "random");
    end

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule